// File: doc/BRIEF.md
# Mesh Route Computation Unit

This block computes the output port for packets passing through one router of a two-dimensional mesh with no wraparound links. The router's own coordinates are static configuration inputs. When a head flit is presented, the block compares the destination coordinates carried by that flit against the router's own position. It then raises exactly one bit of a five-bit output-port request: Local, East, West, North or South.

Two routing policies are selectable per packet. The first is deterministic dimension-order routing, which resolves X fully before Y. The second is a west-first turn-model policy. Under that policy a packet whose destination lies to the west is sent West with no choice. Otherwise, when both an X and a Y move make progress, the policy picks between them using congestion hints from the neighbouring ports. It never requests West in that case.

The port chosen for the head flit is latched when the head is accepted. It is reused for every body and tail flit of the packet, so all flits of a packet leave on one path and stay in order. The latch is cleared when the tail flit is accepted.

Top module: `mesh_route_unit`

## Requirements
- R1: After reset, `pkt_open` is 0 and `pkt_route` is all zeros.
- R2: Port encoding: bit0 Local, bit1 East (larger X), bit2 West (smaller X), bit3 North (larger Y), bit4 South (smaller Y). Whenever `flit_valid` is high and the flit is a head or a packet is open, `port_sel` has exactly one bit set. Otherwise `port_sel` is zero.
- R3: For a head flit whose destination equals the router's own coordinates, `port_sel` is Local (5'b00001) in either mode.
- R4: With `route_mode`=0 (dimension order), a head flit requests East or West while the X coordinates differ. Once X matches, it requests North or South according to the Y offset.
- R5: With `route_mode`=0, the request depends only on the coordinates, never on the congestion hints.
- R6: With `route_mode`=1 (west-first), a head flit whose destination X is smaller than the own X requests West, whatever the hints and the Y offset.
- R7: With `route_mode`=1 and destination X not smaller than the own X, West is never requested. When only one direction makes progress, that direction is requested.
- R8: With `route_mode`=1, when both East and a Y direction make progress, the port with the strictly lower hint is chosen. `hint_north` applies when going North and `hint_south` when going South. A tie selects East.
- R9: Accepting a head flit that is not also a tail (`flit_valid`&`flit_ready`&`flit_head`&!`flit_tail`) sets `pkt_open` and loads `pkt_route` with that flit's port in the next cycle. While the packet is open, non-head flits get `port_sel` = `pkt_route`, whatever their destination fields, mode or hints.
- R10: Accepting a flit with `flit_tail` set clears `pkt_open` and `pkt_route` in the next cycle. A single-flit packet (head and tail together) therefore never opens a packet.
- R11: A flit presented with `flit_ready` low changes neither `pkt_open` nor `pkt_route`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_mode | input | 1 | 0 dimension order, 1 west-first adaptive (sampled on head flits) |
| own_x | input | COORD_W | This router's X coordinate |
| own_y | input | COORD_W | This router's Y coordinate |
| flit_valid | input | 1 | A flit is presented |
| flit_ready | input | 1 | Downstream accepts the presented flit this cycle |
| flit_head | input | 1 | Presented flit is a head flit |
| flit_tail | input | 1 | Presented flit is a tail flit |
| dest_x | input | COORD_W | Destination X from the head flit |
| dest_y | input | COORD_W | Destination Y from the head flit |
| hint_east | input | HINT_W | Congestion hint of the East port |
| hint_north | input | HINT_W | Congestion hint of the North port |
| hint_south | input | HINT_W | Congestion hint of the South port |
| port_sel | output | 5 | One-hot output-port request for the presented flit |
| pkt_open | output | 1 | A multi-flit packet is in progress |
| pkt_route | output | 5 | Port latched for the open packet |

## Verification
The checker watches every cycle for the one-hot shape of the request, Local on zero offsets, and the X-before-Y rule of dimension order. It also watches the forced West move, and the ban on West, of the west-first policy, along with the load, hold and clear of the latched route around accepted heads, accepted tails and stalled flits. Two things depend on comparing specific values across scenarios: that the hints break the choice the right way, ties included, and that dimension order ignores the hints. Only the bench can show these. It does so with directed hint sweeps and randomized packets checked against its own reference.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

  localparam int PORT_N  = 5;
  localparam int P_LOCAL = 0;
  localparam int P_EAST  = 1;
  localparam int P_WEST  = 2;
  localparam int P_NORTH = 3;
  localparam int P_SOUTH = 4;
  localparam int HINT_MAX_W = 8;

  typedef logic [PORT_N-1:0] port_t;

  typedef struct packed {
    logic east;
    logic west;
    logic north;
    logic south;
  } dir_t;

  function automatic port_t port_bit(input int idx);
    port_t p;
    p = '0;
    p[idx] = 1'b1;
    return p;
  endfunction

  // X first, then Y, then Local.
  function automatic port_t route_xy(input dir_t d);
    if (d.east)  return port_bit(P_EAST);
    if (d.west)  return port_bit(P_WEST);
    if (d.north) return port_bit(P_NORTH);
    if (d.south) return port_bit(P_SOUTH);
    return port_bit(P_LOCAL);
  endfunction

  // Westward motion is mandatory and first; afterwards East vs Y by hint.
  function automatic port_t route_wf(input dir_t d,
                                     input logic [HINT_MAX_W-1:0] h_e,
                                     input logic [HINT_MAX_W-1:0] h_n,
                                     input logic [HINT_MAX_W-1:0] h_s);
    logic [HINT_MAX_W-1:0] h_y;
    port_t y_port;
    if (d.west) return port_bit(P_WEST);
    y_port = d.north ? port_bit(P_NORTH) : port_bit(P_SOUTH);
    h_y    = d.north ? h_n : h_s;
    if (d.east && (d.north || d.south))
      return (h_y < h_e) ? y_port : port_bit(P_EAST);
    if (d.east)  return port_bit(P_EAST);
    if (d.north) return port_bit(P_NORTH);
    if (d.south) return port_bit(P_SOUTH);
    return port_bit(P_LOCAL);
  endfunction

endpackage

// File: rtl/mesh_route_offset.sv
module mesh_route_offset
  import mesh_route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] own_x,
  input  logic [COORD_W-1:0] own_y,
  input  logic [COORD_W-1:0] dest_x,
  input  logic [COORD_W-1:0] dest_y,
  output dir_t               dir
);
  always_comb begin
    dir.east  = dest_x > own_x;
    dir.west  = dest_x < own_x;
    dir.north = dest_y > own_y;
    dir.south = dest_y < own_y;
  end
endmodule

// File: rtl/mesh_route_select.sv
module mesh_route_select
  import mesh_route_pkg::*;
#(
  parameter int HINT_W      = 3,
  parameter bit ADAPTIVE_EN = 1'b1
) (
  input  dir_t              dir,
  input  logic              route_mode,
  input  logic [HINT_W-1:0] hint_east,
  input  logic [HINT_W-1:0] hint_north,
  input  logic [HINT_W-1:0] hint_south,
  output port_t             port
);
  port_t xy_port;
  assign xy_port = route_xy(dir);

  generate
    if (ADAPTIVE_EN) begin : g_adapt
      port_t wf_port;
      assign wf_port = route_wf(dir, HINT_MAX_W'(hint_east),
                                HINT_MAX_W'(hint_north), HINT_MAX_W'(hint_south));
      assign port = route_mode ? wf_port : xy_port;
    end else begin : g_fixed
      assign port = xy_port;
    end
  endgenerate
endmodule

// File: rtl/mesh_route_hold.sv
module mesh_route_hold
  import mesh_route_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  logic  clear,
  input  port_t new_route,
  output logic  open,
  output port_t route
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open  <= 1'b0;
      route <= '0;
    end else if (clear) begin
      open  <= 1'b0;
      route <= '0;
    end else if (capture) begin
      open  <= 1'b1;
      route <= new_route;
    end
  end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
  import mesh_route_pkg::*;
#(
  parameter int COORD_W     = 4,
  parameter int HINT_W      = 3,
  parameter bit ADAPTIVE_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               route_mode,
  input  logic [COORD_W-1:0] own_x,
  input  logic [COORD_W-1:0] own_y,
  input  logic               flit_valid,
  input  logic               flit_ready,
  input  logic               flit_head,
  input  logic               flit_tail,
  input  logic [COORD_W-1:0] dest_x,
  input  logic [COORD_W-1:0] dest_y,
  input  logic [HINT_W-1:0]  hint_east,
  input  logic [HINT_W-1:0]  hint_north,
  input  logic [HINT_W-1:0]  hint_south,
  output logic [4:0]         port_sel,
  output logic               pkt_open,
  output logic [4:0]         pkt_route
);
  dir_t  dir;
  port_t head_port;
  logic  flit_accept;
  logic  head_accept;
  logic  tail_accept;

  mesh_route_offset #(.COORD_W(COORD_W)) offset_i (
    .own_x(own_x), .own_y(own_y), .dest_x(dest_x), .dest_y(dest_y), .dir(dir)
  );

  mesh_route_select #(.HINT_W(HINT_W), .ADAPTIVE_EN(ADAPTIVE_EN)) select_i (
    .dir(dir), .route_mode(route_mode), .hint_east(hint_east),
    .hint_north(hint_north), .hint_south(hint_south), .port(head_port)
  );

  assign flit_accept = flit_valid & flit_ready;
  assign head_accept = flit_accept & flit_head & ~flit_tail;
  assign tail_accept = flit_accept & flit_tail;

  mesh_route_hold hold_i (
    .clk(clk), .rst_n(rst_n), .capture(head_accept), .clear(tail_accept),
    .new_route(head_port), .open(pkt_open), .route(pkt_route)
  );

  always_comb begin
    if (!flit_valid)    port_sel = '0;
    else if (flit_head) port_sel = head_port;
    else if (pkt_open)  port_sel = pkt_route;
    else                port_sel = '0;
  end
endmodule

// File: rtl/mesh_route_chk.sv
module mesh_route_chk #(
  parameter int COORD_W     = 4,
  parameter bit ADAPTIVE_EN = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               route_mode,
  input logic [COORD_W-1:0] own_x,
  input logic [COORD_W-1:0] own_y,
  input logic               flit_valid,
  input logic               flit_ready,
  input logic               flit_head,
  input logic               flit_tail,
  input logic [COORD_W-1:0] dest_x,
  input logic [COORD_W-1:0] dest_y,
  input logic [4:0]         port_sel,
  input logic               pkt_open,
  input logic [4:0]         pkt_route,
  input logic               head_accept,
  input logic               tail_accept
);
  logic head_now;
  assign head_now = flit_valid && flit_head;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && (flit_head || pkt_open)) |-> $onehot(port_sel));

  assert_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_now && dest_x == own_x && dest_y == own_y) |-> port_sel == 5'b00001);

  assert_x_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (head_now && !route_mode && dest_x != own_x) |-> (port_sel[1] || port_sel[2]));

  assert_west_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ADAPTIVE_EN && head_now && route_mode && dest_x < own_x) |-> port_sel == 5'b00100);

  assert_no_west_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ADAPTIVE_EN && head_now && route_mode && dest_x >= own_x) |-> !port_sel[2]);

  assert_route_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    head_accept |=> (pkt_open && pkt_route == $past(port_sel)));

  assert_tail_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tail_accept |=> (!pkt_open && pkt_route == 5'b00000));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(flit_valid && flit_ready) |=> ($stable(pkt_open) && $stable(pkt_route)));
endmodule

bind mesh_route_unit mesh_route_chk #(.COORD_W(COORD_W), .ADAPTIVE_EN(ADAPTIVE_EN)) chk_i (
  .clk(clk), .rst_n(rst_n), .route_mode(route_mode), .own_x(own_x), .own_y(own_y),
  .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_head(flit_head),
  .flit_tail(flit_tail), .dest_x(dest_x), .dest_y(dest_y), .port_sel(port_sel),
  .pkt_open(pkt_open), .pkt_route(pkt_route), .head_accept(head_accept),
  .tail_accept(tail_accept)
);

// File: tb/mesh_route_unit_tb_top.sv
module mesh_route_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int HW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          route_mode = 1'b0;
  logic [CW-1:0] own_x = '0, own_y = '0, dest_x = '0, dest_y = '0;
  logic          flit_valid = 1'b0, flit_ready = 1'b0, flit_head = 1'b0, flit_tail = 1'b0;
  logic [HW-1:0] hint_east = '0, hint_north = '0, hint_south = '0;
  logic [4:0]    port_sel, pkt_route;
  logic          pkt_open;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic       m_open = 1'b0;
  logic [4:0] m_route = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesh_route_unit #(.COORD_W(CW), .HINT_W(HW), .ADAPTIVE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .route_mode(route_mode), .own_x(own_x), .own_y(own_y),
    .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_head(flit_head),
    .flit_tail(flit_tail), .dest_x(dest_x), .dest_y(dest_y), .hint_east(hint_east),
    .hint_north(hint_north), .hint_south(hint_south), .port_sel(port_sel),
    .pkt_open(pkt_open), .pkt_route(pkt_route)
  );

  // Reference: signed offsets, then the policy from the requirements.
  function automatic logic [4:0] ref_port(input logic md, input int ox, input int oy,
                                          input int dx, input int dy,
                                          input int he, input int hn, input int hs);
    int ex, ey;
    ex = dx - ox;
    ey = dy - oy;
    if (ex == 0 && ey == 0) return 5'b00001;
    if (!md) begin
      if (ex != 0) return (ex > 0) ? 5'b00010 : 5'b00100;
      return (ey > 0) ? 5'b01000 : 5'b10000;
    end
    if (ex < 0) return 5'b00100;
    if (ey == 0) return 5'b00010;
    if (ex == 0) return (ey > 0) ? 5'b01000 : 5'b10000;
    if (ey > 0) return (hn < he) ? 5'b01000 : 5'b00010;
    return (hs < he) ? 5'b10000 : 5'b00010;
  endfunction

  task automatic check(input bit ok, input string req, input logic [4:0] act,
                       input logic [4:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Present one flit for one cycle, check the request mid-cycle and the
  // latched state after the edge.
  task automatic flit(input logic hd, input logic tl, input logic rdy, input logic md,
                      input int dx, input int dy, input int he, input int hn,
                      input int hs, input string req);
    logic [4:0] exp;
    @(negedge clk);
    flit_valid = 1'b1; flit_head = hd; flit_tail = tl; flit_ready = rdy;
    route_mode = md; dest_x = CW'(dx); dest_y = CW'(dy);
    hint_east = HW'(he); hint_north = HW'(hn); hint_south = HW'(hs);
    #(CLK_PERIOD/4);
    if (hd) exp = ref_port(md, int'(own_x), int'(own_y), dx, dy, he, hn, hs);
    else    exp = m_open ? m_route : 5'b00000;
    check(port_sel == exp, req, port_sel, exp);
    if (rdy) begin
      if (tl) begin m_open = 1'b0; m_route = '0; end
      else if (hd) begin m_open = 1'b1; m_route = exp; end
    end
    @(posedge clk);
    #1;
    check(pkt_open == m_open && pkt_route == m_route,
          rdy ? (tl ? "R10" : "R9") : "R11", {pkt_route[3:0], pkt_open},
          {m_route[3:0], m_open});
    check(pkt_route == m_route, rdy ? "R9" : "R11", pkt_route, m_route);
  endtask

  task automatic idle();
    @(negedge clk);
    flit_valid = 1'b0; flit_head = 1'b0; flit_tail = 1'b0; flit_ready = 1'b0;
    #(CLK_PERIOD/4);
    check(port_sel == 5'b00000, "R2", port_sel, 5'b00000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    own_x = 4'd7; own_y = 4'd5;
    repeat (3) @(posedge clk);
    #1;
    check(pkt_open == 1'b0 && pkt_route == 5'b00000, "R1", pkt_route, 5'b00000);
    @(negedge clk); rst_n = 1'b1;
    idle();

    // R3 local in both modes
    flit(1, 1, 1, 0, 7, 5, 0, 0, 0, "R3");
    flit(1, 1, 1, 1, 7, 5, 3, 1, 6, "R3");
    // R4 dimension order per quadrant, R5 hints irrelevant
    flit(1, 1, 1, 0, 9, 2, 0, 0, 0, "R4");
    flit(1, 1, 1, 0, 1, 12, 0, 0, 0, "R4");
    flit(1, 1, 1, 0, 7, 11, 0, 0, 0, "R4");
    flit(1, 1, 1, 0, 7, 0, 0, 0, 0, "R4");
    flit(1, 1, 1, 0, 12, 9, 7, 0, 0, "R5");
    flit(1, 1, 1, 0, 12, 9, 0, 7, 7, "R5");
    // R6 west forced
    flit(1, 1, 1, 1, 2, 9, 7, 0, 0, "R6");
    flit(1, 1, 1, 1, 0, 5, 0, 7, 7, "R6");
    // R7 single productive direction, never west
    flit(1, 1, 1, 1, 15, 5, 7, 0, 0, "R7");
    flit(1, 1, 1, 1, 7, 14, 0, 7, 0, "R7");
    flit(1, 1, 1, 1, 7, 1, 0, 0, 7, "R7");
    // R8 hint choice and tie
    flit(1, 1, 1, 1, 10, 9, 5, 2, 7, "R8");
    flit(1, 1, 1, 1, 10, 9, 2, 5, 0, "R8");
    flit(1, 1, 1, 1, 10, 9, 4, 4, 0, "R8");
    flit(1, 1, 1, 1, 10, 1, 6, 0, 3, "R8");
    flit(1, 1, 1, 1, 10, 1, 3, 7, 3, "R8");
    // R11 stalled head then R9 open, body with garbage fields, R10 tail
    flit(1, 0, 0, 1, 10, 9, 5, 2, 7, "R11");
    flit(1, 0, 1, 1, 10, 9, 5, 2, 7, "R9");
    flit(0, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
    flit(0, 0, 0, 1, 15, 15, 7, 7, 7, "R11");
    flit(0, 1, 1, 0, 3, 3, 1, 1, 1, "R10");
    idle();

    // Randomized packets
    for (int p = 0; p < 400; p++) begin
      int len, dx, dy;
      logic md;
      if (p % 50 == 0) begin own_x = CW'($urandom_range(0, 15)); own_y = CW'($urandom_range(0, 15)); end
      len = $urandom_range(1, 4);
      md  = 1'($urandom_range(0, 1));
      dx  = $urandom_range(0, 15);
      dy  = $urandom_range(0, 15);
      for (int f = 0; f < len; f++) begin
        logic rdy;
        int rx, ry;
        rdy = ($urandom_range(0, 3) != 0);
        rx = (f == 0) ? dx : $urandom_range(0, 15);
        ry = (f == 0) ? dy : $urandom_range(0, 15);
        flit(f == 0, f == len - 1, rdy, (f == 0) ? md : 1'($urandom_range(0, 1)),
             rx, ry, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
             (f == 0) ? (md ? "R8" : "R4") : "R9");
        if (!rdy) f--;
      end
      if ($urandom_range(0, 3) == 0) idle();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule